// File: doc/BRIEF.md
# Timer Capture/Compare Channel Unit

A 16-bit up-counting timer shared by a set of channels. Each channel either timestamps edges on its own input (capture) or watches for the count to reach its register (compare). In compare mode a per-channel output generator drives a pin, so one channel can set the PWM period and the others can set duty cycles. The count runs from zero up to the value held in channel 0 and then returns to zero, so a period is that value plus one. One count-enable input takes the place of the clock source and prescaler.

Software reaches the counter and every channel through a simple word-wide register bus. Writes take effect at the clock edge. Reads are combinational from the current address. Each channel has an event flag with an enable, and the enabled flags are ORed into one interrupt line.

Top module: `tccu_top`

## Requirements
- R1: After reset the count, every channel register and every control field read as zero, all channel outputs are low and the interrupt is low.
- R2: When the count enable is high and no count write happens, the count steps by one per clock. In the step where the count equals channel 0's register, the count becomes zero instead. With the enable low, the count holds. A write to address 0 loads the count.
- R3: For a channel in compare mode, a step with the count enable high and the count equal to the channel register sets the channel flag at that edge. At the same edge the synchronized input is copied into the shadow bit (control bit 11).
- R4: In capture mode, control bits 2:1 select the edge: 0 none, 1 rising, 2 falling, 3 both. The input passes through two synchronizing flops. The capture lands at the third clock edge after the input changes. It copies the count into the channel register and sets the flag, whatever the count enable.
- R5: A capture while the channel flag is already set sets the overflow bit (control bit 8). That bit stays set until software writes it to 0.
- R6: Control bits 5:3 select the output mode. The codes are: 0 follows output bit 6; 1 set; 2 toggle then reset; 3 set then reset; 4 toggle; 5 reset; 6 toggle then set; 7 reset then set. The first action fires on the channel's own match and the second on channel 0's match. Output actions only occur in compare mode.
- R7: When a channel's own match and channel 0's match fall in the same step, only the first action of the mode is applied.
- R8: In mode 0 the output pin equals control bit 6 from the edge that writes it.
- R9: The interrupt is high exactly when some channel has both its flag (bit 7) and its enable (bit 9) set.
- R10: Address 0 is the count. Channel n uses address 2n+1 for control and 2n+2 for its register. Control bits are: 0 capture mode, 2:1 edge, 5:3 output mode, 6 output bit, 7 flag, 8 overflow, 9 interrupt enable. Three bits are read only: 10 synchronized input, 11 shadow, 12 current output. Unused addresses read zero.
- R11: If a capture and a bus write to the same channel register fall on one edge, the captured count wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable, one count per clock while high |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| capIn | input | 3 | Capture inputs, one per channel |
| cmpOut | output | 3 | Output generator pins, one per channel |
| irq | output | 1 | Combined channel interrupt |

## Verification
Results fall due at different times. Register writes, the count step, compare flags, shadow copies and output actions all show up one edge after their cause. Mode 0 output and the interrupt follow the registers combinationally. A capture appears three edges after the input moves, because of the synchronizer and edge-detect stage. The bench model steps its state at each rising edge using the same pre-edge inputs, drives stimulus 1 ns after the edge and compares every output at the falling edge. Directed checks wait exactly these edge counts before reading back.

// File: rtl/tccu_pkg.sv
package tccu_pkg;
  localparam int CTL_W = 10;   // writable control bits
  localparam int RD_W  = 13;   // control bits seen on a read

  localparam logic [2:0] OM_BIT     = 3'd0;
  localparam logic [2:0] OM_SET     = 3'd1;
  localparam logic [2:0] OM_TGL_RST = 3'd2;
  localparam logic [2:0] OM_SET_RST = 3'd3;
  localparam logic [2:0] OM_TGL     = 3'd4;
  localparam logic [2:0] OM_RST     = 3'd5;
  localparam logic [2:0] OM_TGL_SET = 3'd6;
  localparam logic [2:0] OM_RST_SET = 3'd7;

  typedef struct packed {
    logic wrCcr;    // bus write to the channel register
    logic capTake;  // capture the count into the channel register
  } chStrobe_t;

  // action on the channel's own match
  function automatic logic ownAct(logic [2:0] m, logic q);
    case (m)
      OM_SET, OM_SET_RST:             ownAct = 1'b1;
      OM_TGL_RST, OM_TGL, OM_TGL_SET: ownAct = ~q;
      OM_RST, OM_RST_SET:             ownAct = 1'b0;
      default:                        ownAct = q;
    endcase
  endfunction

  // action on the channel 0 match
  function automatic logic periodAct(logic [2:0] m, logic q);
    case (m)
      OM_TGL_RST, OM_SET_RST: periodAct = 1'b0;
      OM_TGL_SET, OM_RST_SET: periodAct = 1'b1;
      default:                periodAct = q;
    endcase
  endfunction
endpackage

// File: rtl/tccu_dp.sv
module tccu_dp
  import tccu_pkg::*;
#(
  parameter int NCH = 3,
  parameter int W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cntEn,
  input  logic                   wrCnt,
  input  chStrobe_t [NCH-1:0]    chSt,
  input  logic [W-1:0]           wrData,
  input  logic [NCH-1:0]         capIn,
  output logic [W-1:0]           cnt,
  output logic [NCH-1:0][W-1:0]  ccr,
  output logic [NCH-1:0]         syncIn,
  output logic [NCH-1:0]         riseEv,
  output logic [NCH-1:0]         fallEv,
  output logic [NCH-1:0]         eqEv
);
  logic [NCH-1:0] syncA, syncB, syncC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign syncIn = syncB;
  assign riseEv = syncB & ~syncC;
  assign fallEv = ~syncB & syncC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (wrCnt)      cnt <= wrData;
    else if (cntEn)      cnt <= (cnt == ccr[0]) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ccr <= '0;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (chSt[i].capTake)    ccr[i] <= cnt;
        else if (chSt[i].wrCcr) ccr[i] <= wrData;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) eqEv[i] = cntEn && (cnt == ccr[i]);
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !wrCnt && cnt == ccr[0]) |=> (cnt == '0));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !wrCnt) |=> $stable(cnt));

  for (genvar g = 0; g < NCH; g++) begin : gChk
    assert_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
      chSt[g].capTake |=> (ccr[g] == $past(cnt)));
  end
endmodule

// File: rtl/tccu_ctrl.sv
module tccu_ctrl
  import tccu_pkg::*;
#(
  parameter int NCH = 3,
  parameter int W   = 16,
  parameter int AW  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [AW-1:0]          busAddr,
  input  logic                   busWr,
  input  logic [CTL_W-1:0]       ctlWdata,
  input  logic [W-1:0]           cnt,
  input  logic [NCH-1:0][W-1:0]  ccr,
  input  logic [NCH-1:0]         syncIn,
  input  logic [NCH-1:0]         riseEv,
  input  logic [NCH-1:0]         fallEv,
  input  logic [NCH-1:0]         eqEv,
  output logic                   wrCnt,
  output chStrobe_t [NCH-1:0]    chSt,
  output logic [W-1:0]           busRdata,
  output logic [NCH-1:0]         cmpOut,
  output logic                   irq
);
  logic [NCH-1:0]      capMode, outBit, flag, ovf, ie, shadow, outQ, outNext;
  logic [NCH-1:0]      ctlSel, ccrSel, capTake, ownHit, ctlWr;
  logic [NCH-1:0][1:0] capEdge;
  logic [NCH-1:0][2:0] outMode;

  assign wrCnt = busWr && (busAddr == '0);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ctlSel[i]        = busAddr == AW'(2 * i + 1);
      ccrSel[i]        = busAddr == AW'(2 * i + 2);
      ctlWr[i]         = busWr && ctlSel[i];
      capTake[i]       = capMode[i] && ((capEdge[i][0] && riseEv[i]) ||
                                        (capEdge[i][1] && fallEv[i]));
      ownHit[i]        = !capMode[i] && eqEv[i];
      chSt[i].capTake  = capTake[i];
      chSt[i].wrCcr    = busWr && ccrSel[i];
      if (outMode[i] == OM_BIT)                 outNext[i] = outBit[i];
      else if (ownHit[i])                       outNext[i] = ownAct(outMode[i], outQ[i]);
      else if (!capMode[i] && eqEv[0])          outNext[i] = periodAct(outMode[i], outQ[i]);
      else                                      outNext[i] = outQ[i];
      cmpOut[i]        = (outMode[i] == OM_BIT) ? outBit[i] : outQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capMode <= '0; capEdge <= '0; outMode <= '0; outBit <= '0;
      flag    <= '0; ovf     <= '0; ie      <= '0; shadow <= '0; outQ <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ctlWr[i]) begin
          capMode[i] <= ctlWdata[0];
          capEdge[i] <= ctlWdata[2:1];
          outMode[i] <= ctlWdata[5:3];
          outBit[i]  <= ctlWdata[6];
          ie[i]      <= ctlWdata[9];
        end
        if (capTake[i] || ownHit[i]) flag[i] <= 1'b1;
        else if (ctlWr[i])           flag[i] <= ctlWdata[7];
        if (capTake[i] && flag[i])   ovf[i]  <= 1'b1;
        else if (ctlWr[i])           ovf[i]  <= ctlWdata[8];
        if (ownHit[i])               shadow[i] <= syncIn[i];
        outQ[i] <= outNext[i];
      end
    end
  end

  assign irq = |(flag & ie);

  always_comb begin
    busRdata = '0;
    if (busAddr == '0) busRdata = cnt;
    for (int i = 0; i < NCH; i++) begin
      if (ctlSel[i])
        busRdata = {{(W - RD_W){1'b0}}, cmpOut[i], shadow[i], syncIn[i], ie[i],
                    ovf[i], flag[i], outBit[i], outMode[i], capEdge[i], capMode[i]};
      if (ccrSel[i]) busRdata = ccr[i];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gChk
    assert_cmpflag_R3: assert property (@(posedge clk) disable iff (!rstN)
      ownHit[g] |=> flag[g]);
    assert_ovf_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(ovf[g]) && !$past(ctlWr[g])) |-> $past(flag[g]));
    assert_set_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ownHit[g] && outMode[g] == OM_SET) |=> outQ[g]);
  end
endmodule

// File: rtl/tccu_top.sv
module tccu_top
  import tccu_pkg::*;
#(
  parameter int NCH = 3,
  parameter int W   = 16,
  localparam int AW = $clog2(2 * NCH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cntEn,
  input  logic [AW-1:0]  busAddr,
  input  logic           busWr,
  input  logic [W-1:0]   busWdata,
  output logic [W-1:0]   busRdata,
  input  logic [NCH-1:0] capIn,
  output logic [NCH-1:0] cmpOut,
  output logic           irq
);
  logic                  wrCnt;
  chStrobe_t [NCH-1:0]   chSt;
  logic [W-1:0]          cnt;
  logic [NCH-1:0][W-1:0] ccr;
  logic [NCH-1:0]        syncIn, riseEv, fallEv, eqEv;

  tccu_dp #(.NCH(NCH), .W(W)) uDp (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrCnt(wrCnt), .chSt(chSt),
    .wrData(busWdata), .capIn(capIn), .cnt(cnt), .ccr(ccr),
    .syncIn(syncIn), .riseEv(riseEv), .fallEv(fallEv), .eqEv(eqEv)
  );

  tccu_ctrl #(.NCH(NCH), .W(W), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .ctlWdata(busWdata[CTL_W-1:0]), .cnt(cnt), .ccr(ccr), .syncIn(syncIn),
    .riseEv(riseEv), .fallEv(fallEv), .eqEv(eqEv), .wrCnt(wrCnt),
    .chSt(chSt), .busRdata(busRdata), .cmpOut(cmpOut), .irq(irq)
  );
endmodule

// File: tb/sim_tccu_top.sv
`timescale 1ns/1ps
module sim_tccu_top;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [2:0]  capIn = '0;
  logic [2:0]  cmpOut;
  logic        irq;

  int nVec = 0, nErr = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tccu_top u0 (.clk(clk), .rstN(rstN), .cntEn(cntEn), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .capIn(capIn),
    .cmpOut(cmpOut), .irq(irq));

  // behavioural reference state
  int mCnt = 0;
  int mCcr[NCH], mEdge[NCH], mMode[NCH];
  bit mCap[NCH], mOb[NCH], mFlag[NCH], mOvf[NCH], mIe[NCH], mSh[NCH], mOq[NCH];
  bit q1[NCH], q2[NCH], q3[NCH];

  initial for (int i = 0; i < NCH; i++) begin
    mCcr[i] = 0; mEdge[i] = 0; mMode[i] = 0; mCap[i] = 0; mOb[i] = 0;
    mFlag[i] = 0; mOvf[i] = 0; mIe[i] = 0; mSh[i] = 0; mOq[i] = 0;
    q1[i] = 0; q2[i] = 0; q3[i] = 0;
  end

  function automatic bit pinExp(int i);
    return (mMode[i] == 0) ? mOb[i] : mOq[i];
  endfunction

  function automatic int rdExp(int a);
    if (a == 0) return mCnt;
    for (int i = 0; i < NCH; i++) begin
      if (a == 2 * i + 1)
        return int'(mCap[i]) | (mEdge[i] << 1) | (mMode[i] << 3) | (int'(mOb[i]) << 6) |
               (int'(mFlag[i]) << 7) | (int'(mOvf[i]) << 8) | (int'(mIe[i]) << 9) |
               (int'(q2[i]) << 10) | (int'(mSh[i]) << 11) | (int'(pinExp(i)) << 12);
      if (a == 2 * i + 2) return mCcr[i];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    int nCnt; int nCcr[NCH]; bit nFlag[NCH], nOvf[NCH], nSh[NCH], nOq[NCH];
    bit eq0;
    if (!rstN) begin
      mCnt = 0;
      for (int i = 0; i < NCH; i++) begin
        mCcr[i] = 0; mEdge[i] = 0; mMode[i] = 0; mCap[i] = 0; mOb[i] = 0;
        mFlag[i] = 0; mOvf[i] = 0; mIe[i] = 0; mSh[i] = 0; mOq[i] = 0;
        q1[i] = 0; q2[i] = 0; q3[i] = 0;
      end
    end else begin
      eq0 = cntEn && (mCnt == mCcr[0]);
      if (busWr && busAddr == 0) nCnt = int'(busWdata);
      else if (cntEn)            nCnt = eq0 ? 0 : ((mCnt + 1) & 16'hffff);
      else                       nCnt = mCnt;
      for (int i = 0; i < NCH; i++) begin
        bit eq, capT, own, ctlW, ccrW, rise, fall;
        rise = q2[i] && !q3[i];
        fall = !q2[i] && q3[i];
        eq   = cntEn && (mCnt == mCcr[i]);
        capT = mCap[i] && (((mEdge[i] & 1) != 0 && rise) || ((mEdge[i] & 2) != 0 && fall));
        own  = !mCap[i] && eq;
        ctlW = busWr && (busAddr == 3'(2 * i + 1));
        ccrW = busWr && (busAddr == 3'(2 * i + 2));
        nCcr[i]  = capT ? mCnt : (ccrW ? int'(busWdata) : mCcr[i]);
        nFlag[i] = (capT || own) ? 1'b1 : (ctlW ? busWdata[7] : mFlag[i]);
        nOvf[i]  = (capT && mFlag[i]) ? 1'b1 : (ctlW ? busWdata[8] : mOvf[i]);
        nSh[i]   = own ? q2[i] : mSh[i];
        nOq[i]   = mOq[i];
        if (mMode[i] == 0) nOq[i] = mOb[i];
        else if (own) begin
          if (mMode[i] == 1 || mMode[i] == 3) nOq[i] = 1'b1;
          else if (mMode[i] == 5 || mMode[i] == 7) nOq[i] = 1'b0;
          else nOq[i] = !mOq[i];
        end else if (!mCap[i] && eq0) begin
          if (mMode[i] == 2 || mMode[i] == 3) nOq[i] = 1'b0;
          if (mMode[i] == 6 || mMode[i] == 7) nOq[i] = 1'b1;
        end
        if (ctlW) begin
          mCap[i] = busWdata[0]; mEdge[i] = int'(busWdata[2:1]);
          mMode[i] = int'(busWdata[5:3]); mOb[i] = busWdata[6]; mIe[i] = busWdata[9];
        end
      end
      mCnt = nCnt;
      for (int i = 0; i < NCH; i++) begin
        mCcr[i] = nCcr[i]; mFlag[i] = nFlag[i]; mOvf[i] = nOvf[i];
        mSh[i] = nSh[i]; mOq[i] = nOq[i];
        q3[i] = q2[i]; q2[i] = q1[i]; q1[i] = capIn[i];
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    nVec++;
    if (got != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    bit anyIrq;
    anyIrq = 0;
    chk("R10 read data", int'(busRdata), rdExp(int'(busAddr)));
    for (int i = 0; i < NCH; i++) begin
      chk("R6 R7 R8 output pin", int'(cmpOut[i]), int'(pinExp(i)));
      if (mFlag[i] && mIe[i]) anyIrq = 1;
    end
    chk("R9 interrupt", int'(irq), int'(anyIrq));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nErr++;
      $display("FAIL R1 watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  end

  task automatic busWrite(int a, int d);
    @(posedge clk); #1;
    busAddr = 3'(a); busWdata = 16'(d); busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(int a, int mask, int exp, string req);
    busAddr = 3'(a);
    @(negedge clk);
    chk(req, int'(busRdata) & mask, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1: reset values
    for (int a = 0; a < 7; a++) rd(a, 16'hffff, 0, "R1 reset register");
    chk("R1 reset pins", int'(cmpOut), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R8: mode 0 follows the output bit
    busWrite(3, 16'h0040);
    @(negedge clk);
    chk("R8 mode0 pin", int'(cmpOut[1]), 1);

    // R2: wrap at channel 0 register
    busWrite(2, 4);
    busWrite(0, 2);
    cntEn = 1'b1;
    idle(3);
    cntEn = 1'b0;
    rd(0, 16'hffff, 0, "R2 wrap to zero");
    idle(2);
    rd(0, 16'hffff, 0, "R2 hold without enable");

    // R3: compare flag and shadow
    busWrite(2, 9);
    busWrite(4, 3);
    busWrite(3, 16'h0000);
    capIn[1] = 1'b1;
    cntEn = 1'b1;
    idle(25);
    cntEn = 1'b0;
    rd(3, 16'h0880, 16'h0880, "R3 flag and shadow");

    // R6 R7: sweep output modes on channels 0..2
    for (int m = 1; m < 8; m++) begin
      busWrite(1, m << 3);
      busWrite(3, ((m + 3) % 8) << 3);
      busWrite(5, (8 - m) << 3);
      busWrite(6, 5);
      cntEn = 1'b1;
      idle(33);
      cntEn = 1'b0;
    end

    // R4: rising capture with count frozen
    busWrite(1, 0);
    busWrite(3, 0);
    busWrite(0, 16'h1234);
    busWrite(5, 16'h0203);
    capIn[2] = 1'b1;
    idle(4);
    rd(6, 16'hffff, 16'h1234, "R4 rising capture value");
    rd(5, 16'h0080, 16'h0080, "R4 capture flag");
    chk("R9 irq on enabled flag", int'(irq), 1);
    busWrite(0, 16'h0042);
    capIn[2] = 1'b0;
    idle(4);
    rd(6, 16'hffff, 16'h1234, "R4 falling edge ignored in rising mode");

    // R5: overflow on capture with flag set
    busWrite(5, 16'h0287);
    capIn[2] = 1'b1;
    idle(4);
    rd(6, 16'hffff, 16'h0042, "R5 second capture value");
    rd(5, 16'h0100, 16'h0100, "R5 overflow set");
    busWrite(5, 16'h0207);
    rd(5, 16'h0180, 0, "R5 flag and overflow cleared");
    chk("R9 irq cleared", int'(irq), 0);

    // R11: capture collides with a register write
    busWrite(0, 16'h0077);
    capIn[2] = 1'b0;
    idle(1);
    idle(1);
    busAddr = 3'd6; busWdata = 16'h5555; busWr = 1'b1;
    idle(1);
    busWr = 1'b0;
    rd(6, 16'hffff, 16'h0077, "R11 capture beats write");
    rd(5, 16'h0080, 16'h0080, "R11 flag from capture");

    // mixed traffic, checked by the model every clock
    for (int k = 0; k < 4000; k++) begin
      int a, d;
      @(posedge clk); #1;
      a = int'($urandom % 8);
      d = int'($urandom % 65536);
      if (a == 0 || a == 2 || a == 4 || a == 6) d = d % 24;
      busAddr = 3'(a);
      busWdata = 16'(d);
      busWr = ($urandom % 4 == 0);
      cntEn = ($urandom % 8 != 0);
      if ($urandom % 5 == 0) capIn = capIn ^ 3'($urandom % 8);
    end
    busWr = 1'b0;
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule